// File: doc/BRIEF.md
# Serial-to-Parallel Deserializer with Bit-Slip

This block gathers a one-bit NRZ stream into a four-bit parallel word. A free-running phase counter sets the word boundary. It marks one clock edge in every four as the load point, or one in every eight when the block is strapped for cascading. At that edge all four parallel outputs take the four most recently captured bits together, and they hold that value until the next load. The counter also drives two divided clocks, one at a quarter and one at an eighth of the input clock, which downstream logic can use to pick up the word.

A select pin chooses between two serial inputs, so one of them can carry a loopback path for testing. A slip input lets the receiver align to a word boundary it does not yet know. Each pulse on that input holds the phase counter for one edge, which moves every later word by one bit toward the low output. The slip input may arrive from any clock domain. It is brought in through a two-flop synchronizer, and one pulse causes exactly one slip no matter how long it is held.

The bit leaving the end of the capture chain is driven on a serial output. When that output feeds a second instance clocked from the same source, and both instances run in eight-edge mode, they form an eight-bit converter. The instance on the line holds the four newest bits and the downstream instance holds the four before them.

Top module: `ser_to_par_slip`

## Requirements
- R1: The first bit captured after a word boundary appears on par_q[0], the second on par_q[1], the third on par_q[2] and the fourth on par_q[3].
- R2: When sel_a is 1 the stream is taken from sin_a. When sel_a is 0 it is taken from sin_b.
- R3: With mode_byte at 0, par_q loads on every fourth clock edge and holds its value between loads. After reset the first load is on the fourth edge and carries the bits captured on edges 1 to 4.
- R4: With mode_byte at 1, par_q loads on every eighth clock edge with the four bits captured on that edge and the three edges before it. It holds that value for the next seven edges.
- R5: clk_div_word is low after edges 0 and 1 of each four-edge phase and high after edges 2 and 3. It is low after reset.
- R6: clk_div_pair has a period of eight phase counts, is low after reset, and rises only on an edge where clk_div_word falls.
- R7: If sync_in is first sampled high on edge e, the phase counter holds still on edge e+2. Every later load then comes one edge later, so a bit that would have appeared on par_q[n] appears on par_q[n-1].
- R8: A sync_in pulse held high for any number of edges gives exactly one slip. A further slip needs sync_in to be low for at least two edges first.
- R9: ser_out after edge k equals the selected serial bit captured on edge k-3.
- R10: A synchronous rst clears par_q, ser_out, both divided clocks, the capture chain, the phase counter and the synchronizer to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst | input | 1 | Synchronous reset, active high |
| sin_a | input | 1 | Serial input A (loopback path) |
| sin_b | input | 1 | Serial input B (line path) |
| sel_a | input | 1 | 1 selects sin_a, 0 selects sin_b |
| mode_byte | input | 1 | 0: load every 4 edges; 1: load every 8 edges |
| sync_in | input | 1 | Asynchronous slip request |
| par_q | output | WORD_W | Parallel word, bit 0 is the earliest bit |
| ser_out | output | 1 | Retimed serial output for cascading |
| clk_div_word | output | 1 | Input clock divided by 4 |
| clk_div_pair | output | 1 | Input clock divided by 8 |

## Verification
Some properties are checked on every cycle. The phase counter stands still whenever a slip fires. A slip is never followed by another slip on the next edge. The parallel word changes only on a load. Each captured bit enters the top of the chain one edge after it is sampled. The divide-by-8 clock rises only where the divide-by-4 clock falls. Reset clears the outputs. Other behaviour only the bench scenarios can show, because it depends on the data: which bit ends up on which output, the choice between the two inputs, the exact edge on which a slip lands and the shifted words that follow, a long slip pulse giving a single slip, and the eight-edge hold in cascade mode.

// File: rtl/sp_pkg.sv
package sp_pkg;

  typedef enum logic {
    CONV_NIBBLE = 1'b0,
    CONV_BYTE   = 1'b1
  } conv_mode_e;

  localparam int unsigned SP_WORD_W      = 4;
  localparam int unsigned SP_SYNC_STAGES = 2;

  // Width of the phase counter: it spans two words so that the pair mode fits.
  function automatic int unsigned phase_width(input int unsigned word_w);
    return $clog2(2 * word_w);
  endfunction

  // Phase count at which a word is complete, for the given mode.
  function automatic int unsigned term_count(input conv_mode_e m, input int unsigned word_w);
    return (m == CONV_BYTE) ? (2 * word_w - 1) : (word_w - 1);
  endfunction

endpackage

// File: rtl/sp_sync_edge.sv
module sp_sync_edge #(
  parameter int unsigned STAGES = sp_pkg::SP_SYNC_STAGES
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic rise_o
);

  logic [STAGES:0] pipe;

  always_ff @(posedge clk) begin
    if (rst) pipe <= '0;
    else     pipe <= {pipe[STAGES-1:0], async_in};
  end

  assign rise_o = pipe[STAGES-1] & ~pipe[STAGES];

  // R8: one rising edge gives exactly one slip strobe
  p_single_slip_r8: assert property (@(posedge clk) disable iff (rst)
    rise_o |=> !rise_o);

endmodule

// File: rtl/sp_divider.sv
module sp_divider #(
  parameter int unsigned WORD_W = sp_pkg::SP_WORD_W
) (
  input  logic clk,
  input  logic rst,
  input  logic mode_byte,
  input  logic swallow,
  output logic load_o,
  output logic div_word_o,
  output logic div_pair_o
);
  import sp_pkg::*;

  localparam int unsigned CNT_W = phase_width(WORD_W);
  localparam logic [CNT_W-1:0] TERM_NIB = CNT_W'(term_count(CONV_NIBBLE, WORD_W));
  localparam logic [CNT_W-1:0] TERM_BYT = CNT_W'(term_count(CONV_BYTE, WORD_W));

  logic [CNT_W-1:0] cnt;
  logic             at_term;
  conv_mode_e       mode_e;

  assign mode_e = conv_mode_e'(mode_byte);

  always_ff @(posedge clk) begin
    if (rst)           cnt <= '0;
    else if (!swallow) cnt <= cnt + 1'b1;
  end

  generate
    if (CNT_W > 1) begin : g_multi
      always_comb begin
        if (mode_e == CONV_BYTE) at_term = (cnt == TERM_BYT);
        else                     at_term = (cnt[CNT_W-2:0] == TERM_NIB[CNT_W-2:0]);
      end
      assign div_word_o = cnt[CNT_W-2];
    end else begin : g_single
      assign at_term    = (cnt == TERM_BYT);
      assign div_word_o = cnt[0];
    end
  endgenerate

  assign load_o     = at_term & ~swallow;
  assign div_pair_o = cnt[CNT_W-1];

  // R7: a slip strobe freezes the phase for that edge
  p_swallow_hold_r7: assert property (@(posedge clk) disable iff (rst)
    swallow |=> $stable(cnt));

  // R6: the divide-by-8 clock rises only where the divide-by-4 clock falls
  p_pair_follows_word_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(div_pair_o) |-> $fell(div_word_o));

  // R4: in pair mode a load is issued only when both divided clocks are high
  p_byte_load_phase_r4: assert property (@(posedge clk) disable iff (rst)
    (mode_byte && load_o) |-> (div_word_o && div_pair_o));

endmodule

// File: rtl/sp_shift.sv
module sp_shift #(
  parameter int unsigned WORD_W = sp_pkg::SP_WORD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ser_bit,
  input  logic              load,
  output logic [WORD_W-1:0] par_o,
  output logic              sout_o
);

  logic [WORD_W-1:0] chain;
  logic [WORD_W-1:0] chain_nxt;

  // New bits enter at the top, so the earliest one settles at index 0.
  assign chain_nxt = {ser_bit, chain[WORD_W-1:1]};

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= '0;
      par_o <= '0;
    end else begin
      chain <= chain_nxt;
      if (load) par_o <= chain_nxt;
    end
  end

  assign sout_o = chain[0];

  // R9: each captured bit lands at the top of the chain one edge later
  p_chain_entry_r9: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (chain[WORD_W-1] == $past(ser_bit)));

  // R3: the parallel word changes only on a load
  p_par_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(par_o));

endmodule

// File: rtl/ser_to_par_slip.sv
module ser_to_par_slip #(
  parameter int unsigned WORD_W      = sp_pkg::SP_WORD_W,
  parameter int unsigned SYNC_STAGES = sp_pkg::SP_SYNC_STAGES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sin_a,
  input  logic              sin_b,
  input  logic              sel_a,
  input  logic              mode_byte,
  input  logic              sync_in,
  output logic [WORD_W-1:0] par_q,
  output logic              ser_out,
  output logic              clk_div_word,
  output logic              clk_div_pair
);

  logic ser_bit;
  logic slip_fire;
  logic word_load;

  assign ser_bit = sel_a ? sin_a : sin_b;

  sp_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .async_in (sync_in),
    .rise_o   (slip_fire)
  );

  sp_divider #(.WORD_W(WORD_W)) u_div (
    .clk        (clk),
    .rst        (rst),
    .mode_byte  (mode_byte),
    .swallow    (slip_fire),
    .load_o     (word_load),
    .div_word_o (clk_div_word),
    .div_pair_o (clk_div_pair)
  );

  sp_shift #(.WORD_W(WORD_W)) u_shift (
    .clk     (clk),
    .rst     (rst),
    .ser_bit (ser_bit),
    .load    (word_load),
    .par_o   (par_q),
    .sout_o  (ser_out)
  );

  // R10: reset leaves every output at zero
  p_reset_clear_r10: assert property (@(posedge clk)
    rst |=> (par_q == '0 && !ser_out && !clk_div_word && !clk_div_pair));

  // R7: no load happens on an edge where the phase is held
  p_no_load_on_slip_r7: assert property (@(posedge clk) disable iff (rst)
    slip_fire |-> !word_load);

endmodule

// File: tb/tb_ser_to_par_slip.sv
module tb_ser_to_par_slip;

  localparam int W = 4;
  localparam logic [31:0] PAT = 32'hD3A5_61E7;
  // fields: sel[48], sin_a stream[47:32], sin_b stream[31:16], expected words[15:0]
  localparam logic [48:0] VEC [4] = '{
    {1'b1, 16'hA5C3, 16'h0F0F, 16'hA5C3},
    {1'b0, 16'hFFFF, 16'h1E2D, 16'h1E2D},
    {1'b1, 16'h8421, 16'h7BDE, 16'h8421},
    {1'b0, 16'h0000, 16'hC0DE, 16'hC0DE}
  };

  logic clk = 0, rst = 1, sin_a = 0, sin_b = 0, sel_a = 0, mode_byte = 0, sync_in = 0;
  logic [W-1:0] par_q;
  logic ser_out, clk_div_word, clk_div_pair;

  int checks = 0, errors = 0, edge_no = 0, ph = 0, swallow_due = -1;
  logic [31:0] hist = '0;
  logic [W-1:0] exp_par = '0;
  logic prev_sync = 0, done = 0;

  always #10 clk = ~clk;

  ser_to_par_slip dut (.clk(clk), .rst(rst), .sin_a(sin_a), .sin_b(sin_b), .sel_a(sel_a),
    .mode_byte(mode_byte), .sync_in(sync_in), .par_q(par_q), .ser_out(ser_out),
    .clk_div_word(clk_div_word), .clk_div_pair(clk_div_pair));

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h (edge %0d)", tag, act, exp, edge_no);
    end
  endtask

  // One clock: drive inputs, update the reference after the edge, check at the falling edge.
  task automatic tick(input logic a, input logic b, input logic s, input string ptag);
    logic sb, sw, term;
    sin_a = a; sin_b = b; sync_in = s;
    @(posedge clk);
    edge_no++;
    if (rst) begin
      hist = '0; ph = 0; exp_par = '0; swallow_due = -1; prev_sync = 0;
    end else begin
      sb   = sel_a ? a : b;
      hist = {hist[30:0], sb};
      sw   = (edge_no == swallow_due);
      if (s && !prev_sync) swallow_due = edge_no + 2;
      prev_sync = s;
      term = mode_byte ? (ph == 7) : ((ph % 4) == 3);
      if (!sw) ph = (ph + 1) % 8;
      if (term && !sw) exp_par = {hist[0], hist[1], hist[2], hist[3]};
    end
    @(negedge clk);
    chk(par_q, exp_par, ptag);
    chk(clk_div_word, (ph >> 1) & 1, "R5");
    chk(clk_div_pair, (ph >> 2) & 1, "R6");
    chk(ser_out, hist[3], "R9");
  endtask

  task automatic do_reset();
    rst = 1;
    tick(0, 0, 0, "R10");
    tick(0, 0, 0, "R10");
    rst = 0;
  endtask

  task automatic run_pat(input int n, input int base, input string tag);
    for (int i = 0; i < n; i++) tick(PAT[(base + i) % 32], ~PAT[(base + i) % 32], 0, tag);
  endtask

  initial begin
    @(negedge clk);
    // Reset state
    do_reset();
    chk(par_q, 0, "R10"); chk(ser_out, 0, "R10");
    chk(clk_div_word, 0, "R10"); chk(clk_div_pair, 0, "R10");

    // Vector table: bit order and input selection, nibble mode
    for (int v = 0; v < 4; v++) begin
      sel_a = VEC[v][48];
      mode_byte = 0;
      do_reset();
      for (int i = 0; i < 16; i++) begin
        tick(VEC[v][32 + i], VEC[v][16 + i], 0, "R3");
        if ((i % 4) == 3) chk(par_q, VEC[v][i - 3 +: 4], "R1 R2");
      end
    end

    // Single slip
    sel_a = 0; mode_byte = 0;
    do_reset();
    run_pat(9, 0, "R3");
    tick(PAT[9], 0, 1, "R7"); tick(PAT[10], 0, 1, "R7"); tick(PAT[11], 0, 1, "R7");
    sel_a = 1;
    run_pat(12, 12, "R7");
    // Long pulse: one slip only
    for (int i = 0; i < 10; i++) tick(PAT[(i + 3) % 32], 0, 1, "R8");
    run_pat(12, 5, "R8");
    // Two short pulses back to back: two slips
    tick(1, 0, 1, "R7"); tick(0, 0, 1, "R7"); tick(1, 0, 0, "R7"); tick(1, 0, 0, "R7");
    tick(0, 0, 1, "R7"); tick(1, 0, 1, "R7");
    run_pat(16, 20, "R7");

    // Pair mode with a slip
    mode_byte = 1;
    do_reset();
    run_pat(24, 2, "R4");
    tick(1, 0, 1, "R4"); tick(0, 0, 1, "R4");
    run_pat(24, 7, "R4");

    // Reset mid-stream
    do_reset();
    chk(par_q, 0, "R10"); chk(ser_out, 0, "R10");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog act=hung exp=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule